// File: doc/BRIEF.md
# Ping-Pong Strip Buffer Arbiter

This block arbitrates the two faces of a double-buffered strip memory that sits between a pixel-side engine and a coder-side engine. Face 0 is called AB and face 1 is called A'B'. One side produces strips into a face while the other side consumes the opposite face. In encode mode the pixel side produces and the coder side consumes. In decode mode the coder side produces and the pixel side consumes. The block keeps a two-bit status for each face, swaps a side to the other face only when that face is in the right state, and raises a coder-busy flag while the pixel side has to wait.

The pixel side reports the end of each strip with a one-cycle pulse. The coder side moves data in blocks. The arbiter starts each block with a one-cycle sync strobe, and the coder answers with a block-done pulse. A face is complete after a fixed number of blocks. A stop input holds back new sync strobes. In encode mode, an end-of-image pulse closes a partly filled last strip so the coder can drain it. Address generation, the data path and format interleave are outside this block.

Top module: `strip_pingpong_arb`

## Requirements
- R1: After reset, face 0 is filling and face 1 is empty (`face_state_o` = 4'b0001). The producer owns face 0 and the consumer waits on face 1, so in encode `pix_face_o`=0 and `cod_face_o`=1, and in decode `pix_face_o`=1 and `cod_face_o`=0. `cbusy_o` is 0 in encode and 1 in decode. `dsync_o` and `overrun_o` are 0.
- R2: Face status codes are empty=0, filling=1, full=2 and draining=3. Face 0 is in `face_state_o[1:0]` and face 1 is in `face_state_o[3:2]`. When the producer completes a face, that face becomes full. If the other face is empty at that moment, the producer takes it as filling on the same clock edge.
- R3: In encode, when a strip completes while the other face is not empty, `cbusy_o` goes high after that edge. It falls on the edge at which the coder empties that face, and the pixel side moves to it on the same edge.
- R4: In decode, when the pixel side finishes draining a face while the other face is not full, `cbusy_o` goes high. This includes the wait after reset. It falls on the edge at which the coder completes that face.
- R5: The consumer moves to the other face only when that face is full, and marks it draining. Otherwise it waits. A coder side that is waiting issues no `dsync_o`.
- R6: When the coder side owns a usable face and no block is in flight, `dsync_o` pulses for one cycle, one cycle later. The next strobe can follow only after a `blk_done_i`. After BLOCKS_PER_STRIP block-done pulses the coder side has completed its face.
- R7: If `stop_i` is high in a cycle, `dsync_o` is low in the next cycle. Strobes resume once `stop_i` is low.
- R8: `strip_start_i` while `cbusy_o` is high sets `overrun_o`, which stays set until reset. The start does not change any face state.
- R9: In encode, `eoi_i` marks the producer's face full and ends production without asserting `cbusy_o`, so the coder can drain that face. In decode, `eoi_i` has no effect.
- R10: `strip_done_i` while the pixel side waits, or after the end of the image, is ignored. `blk_done_i` with no block in flight is ignored.
- R11: The two faces are never both filling and never both draining. Until the end of the image, the pixel side and the coder side own different faces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| encode_i | input | 1 | 1 = encode (pixel side produces), 0 = decode; held static after reset |
| strip_start_i | input | 1 | Pixel side starts the first line of a strip |
| strip_done_i | input | 1 | Pixel side has finished its strip/face (pulse) |
| eoi_i | input | 1 | End of image, closes the last partial strip in encode (pulse) |
| blk_done_i | input | 1 | Coder side has finished the current block (pulse) |
| stop_i | input | 1 | Holds back new block sync strobes |
| dsync_o | output | 1 | Block transfer start strobe |
| cbusy_o | output | 1 | Pixel side must hold off the next strip |
| overrun_o | output | 1 | Sticky flag: a strip was started while busy |
| pix_face_o | output | 1 | Face owned by the pixel side |
| cod_face_o | output | 1 | Face owned by the coder side |
| face_state_o | output | 4 | Status of face 1 in [3:2] and face 0 in [1:0] |

## Verification
Random strip-done and block-done traffic is run in both modes against a cycle model in the bench. Different strip rates make either side the slower one, which separates the immediate swap from the busy wait in both directions. Bursts of stop with a long stop window separate strobe suppression from the normal one-strobe-per-block pacing. Stray done pulses, starts while busy, and end-of-image pulses in both modes show that ignored events leave the face status untouched while the overrun flag latches.

// File: rtl/spp_pkg.sv
package spp_pkg;
  typedef enum logic [1:0] {
    FACE_EMPTY    = 2'd0,
    FACE_FILLING  = 2'd1,
    FACE_FULL     = 2'd2,
    FACE_DRAINING = 2'd3
  } face_st_e;

  localparam int unsigned NUM_FACES = 2;
endpackage

// File: rtl/spp_face_tracker.sv
module spp_face_tracker
  import spp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prod_done_i,
  input  logic       cons_done_i,
  input  logic       final_i,
  output logic [3:0] face_state_o,
  output logic       prod_face_o,
  output logic       cons_face_o,
  output logic       prod_wait_o,
  output logic       cons_wait_o,
  output logic       ended_o
);
  face_st_e st_q [NUM_FACES];
  face_st_e st_d [NUM_FACES];
  logic pf_q, pf_d, cf_q, cf_d;
  logic pw_q, pw_d, cw_q, cw_d;
  logic end_q, end_d;
  logic pd, cd;

  assign pd = (prod_done_i | final_i) & ~pw_q & ~end_q;
  assign cd = cons_done_i & ~cw_q;

  // events first, then producer resolution, then consumer resolution
  always_comb begin
    st_d  = st_q;
    pf_d  = pf_q;
    cf_d  = cf_q;
    pw_d  = pw_q;
    cw_d  = cw_q;
    end_d = end_q;
    if (cd) begin
      st_d[cf_q] = FACE_EMPTY;
      cw_d       = 1'b1;
    end
    if (pd) begin
      st_d[pf_q] = FACE_FULL;
      if (final_i) end_d = 1'b1;
      else         pw_d  = 1'b1;
    end
    if (pw_d && st_d[~pf_q] == FACE_EMPTY) begin
      pf_d        = ~pf_q;
      st_d[~pf_q] = FACE_FILLING;
      pw_d        = 1'b0;
    end
    if (cw_d && st_d[~cf_q] == FACE_FULL) begin
      cf_d        = ~cf_q;
      st_d[~cf_q] = FACE_DRAINING;
      cw_d        = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q[0] <= FACE_FILLING;
      st_q[1] <= FACE_EMPTY;
      pf_q    <= 1'b0;
      cf_q    <= 1'b1;
      pw_q    <= 1'b0;
      cw_q    <= 1'b1;
      end_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      pf_q  <= pf_d;
      cf_q  <= cf_d;
      pw_q  <= pw_d;
      cw_q  <= cw_d;
      end_q <= end_d;
    end
  end

  for (genvar i = 0; i < NUM_FACES; i++) begin : g_pack
    assign face_state_o[2*i +: 2] = st_q[i];
  end

  assign prod_face_o = pf_q;
  assign cons_face_o = cf_q;
  assign prod_wait_o = pw_q;
  assign cons_wait_o = cw_q;
  assign ended_o     = end_q;
endmodule

// File: rtl/spp_coder_seq.sv
module spp_coder_seq #(
  parameter int unsigned BLOCKS_PER_STRIP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic stop_i,
  input  logic blk_done_i,
  output logic dsync_o,
  output logic face_done_o
);
  localparam int unsigned CNT_W = (BLOCKS_PER_STRIP > 1) ? $clog2(BLOCKS_PER_STRIP) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCKS_PER_STRIP - 1);

  logic [CNT_W-1:0] cnt_q;
  logic busy_q, dsync_q, issue, fin;

  assign issue       = ready_i & ~busy_q & ~stop_i;
  assign fin         = busy_q & blk_done_i;
  assign face_done_o = fin & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      dsync_q <= 1'b0;
    end else begin
      dsync_q <= issue;
      if (fin) begin
        busy_q <= 1'b0;
        cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end else if (issue) begin
        busy_q <= 1'b1;
      end
    end
  end

  assign dsync_o = dsync_q;
endmodule

// File: rtl/strip_pingpong_arb.sv
module strip_pingpong_arb #(
  parameter int unsigned BLOCKS_PER_STRIP = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       encode_i,
  input  logic       strip_start_i,
  input  logic       strip_done_i,
  input  logic       eoi_i,
  input  logic       blk_done_i,
  input  logic       stop_i,
  output logic       dsync_o,
  output logic       cbusy_o,
  output logic       overrun_o,
  output logic       pix_face_o,
  output logic       cod_face_o,
  output logic [3:0] face_state_o
);
  logic prod_face, cons_face, prod_wait, cons_wait, ended;
  logic cod_ready, cod_face_done, prod_done, cons_done;
  logic ovr_q;

  assign prod_done = encode_i ? strip_done_i  : cod_face_done;
  assign cons_done = encode_i ? cod_face_done : strip_done_i;
  assign cod_ready = encode_i ? ~cons_wait    : ~prod_wait;

  spp_face_tracker u_faces (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prod_done_i  (prod_done),
    .cons_done_i  (cons_done),
    .final_i      (eoi_i & encode_i),
    .face_state_o (face_state_o),
    .prod_face_o  (prod_face),
    .cons_face_o  (cons_face),
    .prod_wait_o  (prod_wait),
    .cons_wait_o  (cons_wait),
    .ended_o      (ended)
  );

  spp_coder_seq #(.BLOCKS_PER_STRIP(BLOCKS_PER_STRIP)) u_coder (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (cod_ready),
    .stop_i      (stop_i),
    .blk_done_i  (blk_done_i),
    .dsync_o     (dsync_o),
    .face_done_o (cod_face_done)
  );

  assign cbusy_o    = encode_i ? prod_wait : cons_wait;
  assign pix_face_o = encode_i ? prod_face : cons_face;
  assign cod_face_o = encode_i ? cons_face : prod_face;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ovr_q <= 1'b0;
    else if (strip_start_i && cbusy_o) ovr_q <= 1'b1;
  end

  assign overrun_o = ovr_q;
endmodule

// File: rtl/spp_checker.sv
module spp_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       encode_i,
  input logic       stop_i,
  input logic       strip_start_i,
  input logic       dsync_o,
  input logic       cbusy_o,
  input logic       overrun_o,
  input logic       pix_face_o,
  input logic       cod_face_o,
  input logic [3:0] face_state_o,
  input logic       ended_i
);
  logic [1:0] other_st;
  assign other_st = pix_face_o ? face_state_o[1:0] : face_state_o[3:2];

  assert_enc_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (encode_i && cbusy_o) |-> (other_st != 2'd0));
  assert_dec_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!encode_i && cbusy_o) |-> (other_st != 2'd2));
  assert_sync_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsync_o |=> !dsync_o);
  assert_stop_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !dsync_o);
  assert_ovr_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strip_start_i && cbusy_o) |=> overrun_o);
  assert_ovr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  assert_no_dual_fill_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(face_state_o[1:0] == 2'd1 && face_state_o[3:2] == 2'd1));
  assert_no_dual_drain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(face_state_o[1:0] == 2'd3 && face_state_o[3:2] == 2'd3));
  assert_split_faces_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ended_i |-> (pix_face_o != cod_face_o));
endmodule

bind strip_pingpong_arb spp_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .encode_i      (encode_i),
  .stop_i        (stop_i),
  .strip_start_i (strip_start_i),
  .dsync_o       (dsync_o),
  .cbusy_o       (cbusy_o),
  .overrun_o     (overrun_o),
  .pix_face_o    (pix_face_o),
  .cod_face_o    (cod_face_o),
  .face_state_o  (face_state_o),
  .ended_i       (ended)
);

// File: tb/strip_pingpong_arb_test.sv
module strip_pingpong_arb_test;
  localparam int unsigned NB = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enc = 1'b1, ss = 1'b0, sd = 1'b0, eo = 1'b0, bd = 1'b0, st = 1'b0;
  logic dsync, cbusy, ovr, pixf, codf;
  logic [3:0] fstate;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  strip_pingpong_arb #(.BLOCKS_PER_STRIP(NB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .encode_i(enc), .strip_start_i(ss),
    .strip_done_i(sd), .eoi_i(eo), .blk_done_i(bd), .stop_i(st),
    .dsync_o(dsync), .cbusy_o(cbusy), .overrun_o(ovr),
    .pix_face_o(pixf), .cod_face_o(codf), .face_state_o(fstate)
  );

  // reference state, built from the requirements
  logic [1:0] m_f [2];
  logic m_pf, m_cf, m_pw, m_cw, m_end, m_inblk, m_ds, m_ovr;
  int   m_cnt;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_init();
    m_f[0] = 2'd1; m_f[1] = 2'd0;
    m_pf = 1'b0; m_cf = 1'b1; m_pw = 1'b0; m_cw = 1'b1; m_end = 1'b0;
    m_inblk = 1'b0; m_ds = 1'b0; m_ovr = 1'b0; m_cnt = 0;
  endtask

  function automatic logic exp_busy();
    return enc ? m_pw : m_cw;
  endfunction

  task automatic model_step();
    logic ready, issue, cdone, pd, cd, fin;
    ready = enc ? !m_cw : !m_pw;
    issue = ready && !m_inblk && !st;
    m_ovr = m_ovr | (ss && exp_busy());
    cdone = 1'b0;
    if (m_inblk && bd) begin
      m_inblk = 1'b0;
      if (m_cnt == NB - 1) begin cdone = 1'b1; m_cnt = 0; end
      else m_cnt++;
    end else if (issue) m_inblk = 1'b1;
    m_ds = issue;
    fin = enc && eo;
    pd  = ((enc ? sd : cdone) || fin) && !m_pw && !m_end;
    cd  = (enc ? cdone : sd) && !m_cw;
    if (cd) begin m_f[m_cf] = 2'd0; m_cw = 1'b1; end
    if (pd) begin
      m_f[m_pf] = 2'd2;
      if (fin) m_end = 1'b1; else m_pw = 1'b1;
    end
    if (m_pw && m_f[!m_pf] == 2'd0) begin
      m_pf = !m_pf; m_f[m_pf] = 2'd1; m_pw = 1'b0;
    end
    if (m_cw && m_f[!m_cf] == 2'd2) begin
      m_cf = !m_cf; m_f[m_cf] = 2'd3; m_cw = 1'b0;
    end
  endtask

  task automatic compare_all();
    check("R5", "face_state", int'(fstate), int'({m_f[1], m_f[0]}));
    check("R11", "pix_face", int'(pixf), int'(enc ? m_pf : m_cf));
    check("R11", "cod_face", int'(codf), int'(enc ? m_cf : m_pf));
    check(enc ? "R3" : "R4", "cbusy", int'(cbusy), int'(exp_busy()));
    check("R6", "dsync", int'(dsync), int'(m_ds));
    check("R8", "overrun", int'(ovr), int'(m_ovr));
  endtask

  // drive one cycle's inputs, advance across the edge, compare away from it
  task automatic cycle(logic i_sd, logic i_ss, logic i_eo, logic i_bd, logic i_st);
    sd = i_sd; ss = i_ss; eo = i_eo; bd = i_bd; st = i_st;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(logic mode);
    rst_ni = 1'b0; enc = mode;
    sd = 0; ss = 0; eo = 0; bd = 0; st = 0;
    repeat (2) @(negedge clk);
    model_init();
    rst_ni = 1'b1;
    // R1 reset state
    check("R1", "face_state", int'(fstate), 1);
    check("R1", "pix_face", int'(pixf), mode ? 0 : 1);
    check("R1", "cod_face", int'(codf), mode ? 1 : 0);
    check("R1", "cbusy", int'(cbusy), mode ? 0 : 1);
    check("R1", "dsync", int'(dsync), 0);
    check("R1", "overrun", int'(ovr), 0);
  endtask

  task automatic rnd(int n, int sd_mod, int stop_pct, int eoi_pct, int ss_pct);
    for (int i = 0; i < n; i++) begin
      logic r_bd;
      r_bd = m_inblk ? logic'($urandom % 2) : logic'(($urandom % 16) == 0); // stray ones: R10
      cycle(logic'(($urandom % sd_mod) == 0), logic'(($urandom % 100) < ss_pct),
            logic'(($urandom % 1000) < eoi_pct), r_bd, logic'(($urandom % 100) < stop_pct));
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // ---- encode ----
    do_reset(1'b1);
    cycle(1, 0, 0, 0, 0);                    // R2 immediate swap
    check("R2", "face_state after first strip", int'(fstate), 4'b0111);
    check("R2", "pix_face after first strip", int'(pixf), 1);
    cycle(0, 0, 0, 0, 0);
    check("R6", "first dsync", int'(dsync), 1);
    cycle(1, 0, 0, 0, 0);                    // R3 second strip while coder busy
    check("R3", "cbusy set", int'(cbusy), 1);
    check("R3", "face_state waiting", int'(fstate), 4'b1011);
    cycle(1, 0, 0, 0, 0);                    // R10 ignored while waiting
    check("R10", "face_state unchanged", int'(fstate), 4'b1011);
    for (int b = 0; b < NB; b++) begin
      cycle(0, 0, 0, 1, 0);
      if (b < NB - 1) begin
        cycle(0, 0, 0, 0, 0);
        check("R6", "dsync per block", int'(dsync), 1);
      end
    end
    check("R3", "cbusy cleared on drain", int'(cbusy), 0);
    check("R5", "faces swapped", int'(fstate), 4'b1101);
    for (int k = 0; k < 30; k++) begin       // R7 stop window
      cycle(0, 0, 0, m_inblk, 1);
      check("R7", "dsync under stop", int'(dsync), 0);
    end
    rnd(3000, 6, 10, 0, 0);
    rnd(3000, 30, 30, 0, 0);                 // slow pixel side
    cycle(0, 0, 0, 0, 0);
    cycle(m_pw ? 1'b0 : 1'b1, 0, 0, 0, 0);
    while (!cbusy) cycle(1, 0, 0, 0, 0);
    cycle(0, 1, 0, 0, 0);                    // R8 start while busy
    check("R8", "overrun set", int'(ovr), 1);
    rnd(500, 8, 5, 0, 5);
    while (m_pw) cycle(0, 0, 0, m_inblk, 0);
    cycle(0, 0, 1, 0, 0);                    // R9 end of image
    check("R9", "no cbusy at end", int'(cbusy), 0);
    rnd(400, 4, 5, 0, 0);
    // ---- decode ----
    do_reset(1'b0);
    cycle(0, 0, 0, 0, 0);
    check("R6", "decode first dsync", int'(dsync), 1);
    cycle(0, 0, 1, 0, 0);                    // R9 ignored in decode
    check("R9", "decode eoi face_state", int'(fstate), 4'b0001);
    check("R4", "decode cbusy before fill", int'(cbusy), 1);
    rnd(3000, 6, 10, 20, 0);
    rnd(3000, 40, 25, 20, 3);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule